// File: doc/BRIEF.md
# TLB Selective Invalidation Sequencer

This block owns the tag storage of a two-region translation buffer and removes entries from it on request. The first region is set-associative (`SA_WAYS` ways of `SA_LINES` lines). All of its entries share one page size, which is supplied on an input port. The second region is fully associative (`FA_N` entries), and each of its entries carries its own page size. An entry is a global flag, an address-space identifier, a virtual page-pair number (the address bits from bit 13 upward) and a page-size field, plus an "exists" bit. An invalidation only ever clears the exists bit.

A request is an operation code together with an ASID, a virtual address, an index and a global value. The request is taken in one cycle. The sequencer then examines one entry per cycle, and a one-cycle `done` pulse marks the end. The matching rule depends on the operation. Some operations test the global flag, some test the ASID, and some test the page, with the compare shift taken from the relevant page size. Two index-driven operations narrow the walk: in the set-associative region they cover a single line across all ways, and otherwise they cover the whole associative region. A plain write port loads entries, and a one-bit read port returns the exists bit of any entry.

Entries are numbered flat. Set-associative entry (way w, line l) has number w*SA_LINES + l. Associative entry k has number SA_ENTRIES + k.

Top module: `tlbinv_top`

## Requirements
- R1: After reset every exists bit reads 0, and `busy` and `done` are low.
- R2: When `busy` is low, a write with `wr_en` stores the payload and sets the exists bit of entry `wr_idx` to `wr_exist`. When `busy` is high, a write changes nothing.
- R3: Code 0 (all) clears every entry.
- R4: Code 1 (global-equal) clears each entry whose global flag equals `op_g`.
- R5: Code 2 (asid) clears each non-global entry whose ASID equals `op_asid`.
- R6: Code 3 (page+asid) clears an entry when it is non-global, its ASID equals `op_asid`, and its page matches.
- R7: Code 4 (page, asid-or-global) clears an entry when its page matches and it is either global or has an ASID equal to `op_asid`.
- R8: The page matches when (`op_va` >> (ps+1)) equals (vppn >> (ps+1-13)). For set-associative entries, ps is `sa_ps` as sampled when the request is accepted, and the stored field is ignored. For associative entries, ps is the stored field.
- R9: Codes 5 and 6 choose their scope from `op_index`. An index below SA_ENTRIES covers line (`op_index` mod SA_LINES) in every way. An index from SA_ENTRIES up to TOTAL-1 covers every associative entry. A larger index covers nothing.
- R10: Within its scope, code 5 (index clear) clears non-global entries whose ASID equals `op_asid`. Code 6 (index flush) clears every entry in scope.
- R11: A request is accepted on a clock edge where `start` is high and `busy` is low. N is the number of entries covered: TOTAL for codes 0 to 4, SA_WAYS for a line scope, FA_N for the associative scope, and 0 otherwise. `done` pulses for one cycle, raised by the edge that comes N+1 edges after the accepting edge. When N is 0, the accepting edge itself raises `done`. `busy` is high from the accepting edge until `done` rises, and it falls on the same edge.
- R12: `start` is ignored while `busy` is high.
- R13: Code 7 changes no entry and produces `done` with N = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| op_asid | input | ASID_W | ASID operand |
| op_va | input | VA_W | Virtual address operand |
| op_index | input | IW | Index operand for codes 5 and 6 |
| op_g | input | 1 | Global value operand for code 1 |
| sa_ps | input | PS_W | Page size shared by the set-associative region |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | AW | Entry number to write |
| wr_exist | input | 1 | Exists bit to store |
| wr_g | input | 1 | Global flag to store |
| wr_asid | input | ASID_W | ASID to store |
| wr_vppn | input | VA_W-13 | Page-pair number to store |
| wr_ps | input | PS_W | Page size to store |
| rd_idx | input | AW | Entry number to read |
| rd_exist | output | 1 | Exists bit of `rd_idx`, one cycle later |

## Verification
The following are checked on every cycle:
- `done` never coincides with `busy`, and `busy` only falls together with a `done`.
- While a walk runs, no exists bit rises, so writes and refused requests cannot leak into the storage.
- The latched operation and shared page size hold still while a walk runs.

The bench's sweeps are the only evidence for the following:
- Which entries each operation clears. This covers the ASID and global rules, the page compare at each page size, and the index-to-scope mapping, including indices that are out of range.
- The exact `done` latency for each scope.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  typedef enum logic [2:0] {
    OP_ALL       = 3'd0,
    OP_GLOB_EQ   = 3'd1,
    OP_ASID      = 3'd2,
    OP_PG_ASID   = 3'd3,
    OP_PG_ASID_G = 3'd4,
    OP_IDX_CLR   = 3'd5,
    OP_IDX_FLUSH = 3'd6,
    OP_NOP       = 3'd7
  } inv_op_e;

  typedef enum logic [1:0] {
    SC_NONE = 2'd0,
    SC_ALL  = 2'd1,
    SC_LINE = 2'd2,
    SC_FA   = 2'd3
  } scan_e;
endpackage

// File: rtl/tlbinv_scan.sv
module tlbinv_scan
  import tlbinv_pkg::*;
#(
  parameter int TOTAL    = 2112,
  parameter int SA_WAYS  = 8,
  parameter int SA_LINES = 256,
  parameter int FA_N     = 64,
  parameter int AW       = 12,
  parameter int LW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  scan_e         kind,
  input  logic [LW-1:0] line,
  output logic          issue_vld,
  output logic [AW-1:0] issue_addr,
  output logic          issue_last
);
  localparam int SA_SIZE = SA_WAYS * SA_LINES;

  logic          active;
  logic [AW-1:0] cnt;
  logic [AW-1:0] lim;
  scan_e         kind_q;
  logic [LW-1:0] line_q;

  always_comb begin
    case (kind_q)
      SC_LINE: begin
        lim        = AW'(SA_WAYS - 1);
        issue_addr = AW'(cnt * SA_LINES) + AW'(line_q);
      end
      SC_FA: begin
        lim        = AW'(FA_N - 1);
        issue_addr = AW'(SA_SIZE) + cnt;
      end
      default: begin
        lim        = AW'(TOTAL - 1);
        issue_addr = cnt;
      end
    endcase
  end

  assign issue_vld  = active;
  assign issue_last = active && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      kind_q <= SC_NONE;
      line_q <= '0;
    end else if (launch && kind != SC_NONE) begin
      active <= 1'b1;
      cnt    <= '0;
      kind_q <= kind;
      line_q <= line;
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (cnt == lim) active <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbinv_store.sv
module tlbinv_store #(
  parameter int TOTAL = 2112,
  parameter int AW    = 12,
  parameter int PW    = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PW-1:0]    wdata,
  input  logic             wexist,
  input  logic [AW-1:0]    raddr,
  output logic [PW-1:0]    rdata,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_addr,
  input  logic [AW-1:0]    hraddr,
  output logic             hrexist,
  output logic [TOTAL-1:0] exist_vec
);
  logic [PW-1:0] mem [TOTAL];

  // Payload array: synchronous write and read, no reset, so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // Exists bits live in flops so that a reset clears them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      exist_vec <= '0;
      hrexist   <= 1'b0;
    end else begin
      if (we)     exist_vec[waddr]    <= wexist;
      if (clr_en) exist_vec[clr_addr] <= 1'b0;
      hrexist <= exist_vec[hraddr];
    end
  end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int ASID_W   = 10,
  parameter int VA_W     = 48,
  parameter int PS_W     = 6,
  parameter int PAGE_LSB = 13
) (
  input  inv_op_e                 op,
  input  logic [ASID_W-1:0]       asid,
  input  logic                    g_val,
  input  logic [VA_W-1:0]         va,
  input  logic [PS_W-1:0]         ps,
  input  logic                    e_g,
  input  logic [ASID_W-1:0]       e_asid,
  input  logic [VA_W-PAGE_LSB-1:0] e_vppn,
  output logic                    hit
);
  logic [VA_W-1:0] diff;
  logic [PS_W:0]   sh;
  logic            page_hit;
  logic            asid_hit;

  assign sh       = {1'b0, ps} + 1'b1;
  assign diff     = va ^ {e_vppn, {PAGE_LSB{1'b0}}};
  assign page_hit = ((diff >> sh) == '0);
  assign asid_hit = (e_asid == asid);

  always_comb begin
    case (op)
      OP_ALL:       hit = 1'b1;
      OP_GLOB_EQ:   hit = (e_g == g_val);
      OP_ASID:      hit = !e_g && asid_hit;
      OP_PG_ASID:   hit = !e_g && asid_hit && page_hit;
      OP_PG_ASID_G: hit = (e_g || asid_hit) && page_hit;
      OP_IDX_CLR:   hit = !e_g && asid_hit;
      OP_IDX_FLUSH: hit = 1'b1;
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlbinv_top.sv
module tlbinv_top
  import tlbinv_pkg::*;
#(
  parameter int SA_WAYS  = 8,
  parameter int SA_LINES = 256,
  parameter int FA_N     = 64,
  parameter int ASID_W   = 10,
  parameter int VA_W     = 48,
  parameter int PS_W     = 6,
  parameter int PAGE_LSB = 13,
  localparam int SA_SIZE = SA_WAYS * SA_LINES,
  localparam int TOTAL   = SA_SIZE + FA_N,
  localparam int AW      = $clog2(TOTAL),
  localparam int IW      = AW + 1,
  localparam int LW      = $clog2(SA_LINES),
  localparam int VPPN_W  = VA_W - PAGE_LSB,
  localparam int PW      = 1 + ASID_W + VPPN_W + PS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ASID_W-1:0] op_asid,
  input  logic [VA_W-1:0]   op_va,
  input  logic [IW-1:0]     op_index,
  input  logic              op_g,
  input  logic [PS_W-1:0]   sa_ps,
  output logic              busy,
  output logic              done,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic              wr_exist,
  input  logic              wr_g,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPPN_W-1:0] wr_vppn,
  input  logic [PS_W-1:0]   wr_ps,
  input  logic [AW-1:0]     rd_idx,
  output logic              rd_exist
);
  logic              accept;
  scan_e             kind_d;
  inv_op_e           op_q;
  logic [ASID_W-1:0] asid_q;
  logic [VA_W-1:0]   va_q;
  logic              g_q;
  logic [PS_W-1:0]   ps_q;
  logic              busy_q, done_q;

  logic              iss_vld, iss_last;
  logic [AW-1:0]     iss_addr;
  logic              s1_vld, s1_last;
  logic [AW-1:0]     s1_addr;
  logic [PW-1:0]     rdata;
  logic [TOTAL-1:0]  exist_vec;

  logic              e_g;
  logic [ASID_W-1:0] e_asid;
  logic [VPPN_W-1:0] e_vppn;
  logic [PS_W-1:0]   e_ps;
  logic [PS_W-1:0]   ps_eff;
  logic              hit;

  assign accept = start && !busy_q;

  always_comb begin
    case (inv_op_e'(op))
      OP_IDX_CLR, OP_IDX_FLUSH: begin
        if (op_index < IW'(SA_SIZE))     kind_d = SC_LINE;
        else if (op_index < IW'(TOTAL))  kind_d = SC_FA;
        else                             kind_d = SC_NONE;
      end
      OP_NOP:  kind_d = SC_NONE;
      default: kind_d = SC_ALL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_NOP;
      asid_q <= '0;
      va_q   <= '0;
      g_q    <= 1'b0;
      ps_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      s1_vld <= 1'b0;
      s1_last <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_vld  <= iss_vld;
      s1_last <= iss_last;
      s1_addr <= iss_addr;
      done_q  <= (accept && kind_d == SC_NONE) || (s1_vld && s1_last);
      if (accept) begin
        op_q   <= inv_op_e'(op);
        asid_q <= op_asid;
        va_q   <= op_va;
        g_q    <= op_g;
        ps_q   <= sa_ps;
        busy_q <= (kind_d != SC_NONE);
      end else if (s1_vld && s1_last) begin
        busy_q <= 1'b0;
      end
    end
  end

  tlbinv_scan #(
    .TOTAL(TOTAL), .SA_WAYS(SA_WAYS), .SA_LINES(SA_LINES),
    .FA_N(FA_N), .AW(AW), .LW(LW)
  ) u_scan (
    .clk(clk), .rst(rst), .launch(accept), .kind(kind_d),
    .line(op_index[LW-1:0]), .issue_vld(iss_vld),
    .issue_addr(iss_addr), .issue_last(iss_last)
  );

  tlbinv_store #(.TOTAL(TOTAL), .AW(AW), .PW(PW)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_en && !busy_q), .waddr(wr_idx),
    .wdata({wr_g, wr_asid, wr_vppn, wr_ps}), .wexist(wr_exist),
    .raddr(iss_addr), .rdata(rdata),
    .clr_en(s1_vld && hit), .clr_addr(s1_addr),
    .hraddr(rd_idx), .hrexist(rd_exist), .exist_vec(exist_vec)
  );

  assign {e_g, e_asid, e_vppn, e_ps} = rdata;
  assign ps_eff = (s1_addr < AW'(SA_SIZE)) ? ps_q : e_ps;

  tlbinv_match #(
    .ASID_W(ASID_W), .VA_W(VA_W), .PS_W(PS_W), .PAGE_LSB(PAGE_LSB)
  ) u_match (
    .op(op_q), .asid(asid_q), .g_val(g_q), .va(va_q), .ps(ps_eff),
    .e_g(e_g), .e_asid(e_asid), .e_vppn(e_vppn), .hit(hit)
  );

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/tlbinv_chk.sv
module tlbinv_chk
  import tlbinv_pkg::*;
#(
  parameter int TOTAL = 2112,
  parameter int PS_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic [TOTAL-1:0] exist_vec,
  input inv_op_e          op_q,
  input logic [PS_W-1:0]  ps_q
);
  // R11: completion is never reported while a walk is still running
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: a walk only ends together with its completion pulse
  p_busy_ends_done_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2: nothing sets an exists bit while a walk is running
  p_no_rise_busy_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((exist_vec & ~$past(exist_vec)) == '0));

  // R12: a refused request leaves the latched operation untouched
  p_op_hold_r12: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(op_q));

  // R8: the shared page size is frozen for the whole walk
  p_ps_hold_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ps_q));
endmodule

bind tlbinv_top tlbinv_chk #(.TOTAL(TOTAL), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .exist_vec(exist_vec), .op_q(op_q), .ps_q(ps_q)
);

// File: tb/tb_tlbinv_top.sv
module tb_tlbinv_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 4;
  localparam int LINES = 8;
  localparam int FAN   = 4;
  localparam int ASW   = 10;
  localparam int VAW   = 32;
  localparam int PSW   = 6;
  localparam int SAS   = WAYS * LINES;
  localparam int TOT   = SAS + FAN;
  localparam int AW    = $clog2(TOT);
  localparam int IW    = AW + 1;
  localparam int VPW   = VAW - 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [ASW-1:0] op_asid = '0;
  logic [VAW-1:0] op_va = '0;
  logic [IW-1:0] op_index = '0;
  logic op_g = 1'b0;
  logic [PSW-1:0] sa_ps = 6'd13;
  logic busy, done;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_idx = '0;
  logic wr_exist = 1'b0, wr_g = 1'b0;
  logic [ASW-1:0] wr_asid = '0;
  logic [VPW-1:0] wr_vppn = '0;
  logic [PSW-1:0] wr_ps = '0;
  logic [AW-1:0] rd_idx = '0;
  logic rd_exist;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit m_ex [TOT];
  bit m_g [TOT];
  int m_asid [TOT];
  int m_vppn [TOT];
  int m_ps [TOT];

  tlbinv_top #(
    .SA_WAYS(WAYS), .SA_LINES(LINES), .FA_N(FAN),
    .ASID_W(ASW), .VA_W(VAW), .PS_W(PSW), .PAGE_LSB(13)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .op_asid(op_asid),
    .op_va(op_va), .op_index(op_index), .op_g(op_g), .sa_ps(sa_ps),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_exist(wr_exist), .wr_g(wr_g), .wr_asid(wr_asid),
    .wr_vppn(wr_vppn), .wr_ps(wr_ps), .rd_idx(rd_idx), .rd_exist(rd_exist)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr_entry(input int i, input bit ex, input bit g, input int asid,
                          input int vppn, input int ps);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = AW'(i); wr_exist = ex; wr_g = g;
    wr_asid = ASW'(asid); wr_vppn = VPW'(vppn); wr_ps = PSW'(ps);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all(input int seed);
    for (int i = 0; i < TOT; i++) begin
      m_ex[i]   = ((i + seed) % 5) != 0;
      m_g[i]    = ((i + seed) % 3) == 0;
      m_asid[i] = (i + seed) % 4;
      m_vppn[i] = (i * 7 + seed) % 16;
      // set-associative slots get a deliberately wrong stored size (R8)
      m_ps[i]   = (i < SAS) ? 20 : 12 + ((i + seed) % 4);
      wr_entry(i, m_ex[i], m_g[i], m_asid[i], m_vppn[i], m_ps[i]);
    end
  endtask

  task automatic verify_all(input string tag);
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk);
      rd_idx = AW'(i);
      @(negedge clk);
      check(tag, int'(rd_exist), int'(m_ex[i]), $sformatf("exists[%0d]", i));
    end
  endtask

  function automatic bit page_ok(input longint va, input int vppn, input int ps);
    return (va >> (ps + 1)) == (longint'(vppn) >> (ps + 1 - 13));
  endfunction

  // Expected effect and walk length, computed from the requirements
  function automatic int model_op(input int opc, input int asid, input longint va,
                                  input int idx, input bit g, input int sps);
    int n;
    bit in_scope, hit;
    int ps;
    if (opc == 7) return 0;
    if (opc >= 5) n = (idx < SAS) ? WAYS : ((idx < TOT) ? FAN : 0);
    else          n = TOT;
    for (int i = 0; i < TOT; i++) begin
      ps = (i < SAS) ? sps : m_ps[i];
      if (opc >= 5) begin
        if (idx < SAS)      in_scope = (i < SAS) && ((i % LINES) == (idx % LINES));
        else if (idx < TOT) in_scope = (i >= SAS);
        else                in_scope = 0;
      end else in_scope = 1;
      case (opc)
        0: hit = 1;
        1: hit = (m_g[i] == g);
        2: hit = !m_g[i] && (m_asid[i] == asid);
        3: hit = !m_g[i] && (m_asid[i] == asid) && page_ok(va, m_vppn[i], ps);
        4: hit = (m_g[i] || (m_asid[i] == asid)) && page_ok(va, m_vppn[i], ps);
        5: hit = !m_g[i] && (m_asid[i] == asid);
        default: hit = 1;
      endcase
      if (in_scope && hit) m_ex[i] = 0;
    end
    return n;
  endfunction

  task automatic run_op(input string tag, input int opc, input int asid, input longint va,
                        input int idx, input bit g, input int sps);
    int n, cyc;
    n = model_op(opc, asid, va, idx, g, sps);
    @(negedge clk);
    start = 1'b1; op = 3'(opc); op_asid = ASW'(asid); op_va = VAW'(va);
    op_index = IW'(idx); op_g = g; sa_ps = PSW'(sps);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    sa_ps = PSW'(sps + 1);  // later changes must not matter (R8)
    check("R11", int'(busy), int'(n > 0), "busy after accept");
    cyc = 0;
    if (!done) begin
      while (cyc < 5000) begin
        @(posedge clk);
        cyc++;
        @(negedge clk);
        if (done) break;
      end
    end
    check("R11", cyc, (n == 0) ? 0 : n + 1, "done latency");
    @(negedge clk);
    check("R11", int'(done), 0, "done pulse width");
    verify_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", int'(busy), 0, "busy");
    check("R1", int'(done), 0, "done");
    for (int i = 0; i < TOT; i++) m_ex[i] = 0;
    verify_all("R1");

    // R2: loading through the write port
    load_all(0);
    verify_all("R2");

    // R3
    for (int s = 0; s < 2; s++) begin
      load_all(s);
      run_op("R3", 0, 0, 0, 0, 0, 13);
    end
    // R4
    for (int g = 0; g < 2; g++) begin
      load_all(g + 1);
      run_op("R4", 1, 0, 0, 0, g[0], 13);
    end
    // R5
    for (int a = 0; a < 4; a++) begin
      load_all(a);
      run_op("R5", 2, a, 0, 0, 0, 13);
    end
    // R6, R7, R8: page compare across sizes and addresses
    for (int o = 3; o <= 4; o++) begin
      for (int a = 0; a < 4; a += 1) begin
        for (int v = 0; v < 16; v += 5) begin
          for (int p = 13; p <= 14; p++) begin
            load_all(a + v);
            run_op((o == 3) ? "R6_R8" : "R7_R8", o, a, longint'(v) << 13, 0, 0, p);
          end
        end
      end
    end
    // R9, R10: index scopes, including out-of-range indices
    for (int o = 5; o <= 6; o++) begin
      for (int idx = 0; idx < TOT + 3; idx++) begin
        load_all(idx);
        run_op((o == 5) ? "R9_R10_clr" : "R9_R10_flush", o, 1, 0, idx, 0, 13);
      end
    end
    // R13: code 7 changes nothing
    load_all(3);
    run_op("R13", 7, 0, 0, 0, 0, 13);

    // R12 and R2: start and write during a walk are both ignored
    load_all(4);
    begin
      int n;
      n = model_op(1, 0, 0, 0, 1'b1, 13);
      @(negedge clk);
      start = 1'b1; op = 3'd1; op_g = 1'b1;
      @(negedge clk);
      start = 1'b1; op = 3'd0;            // would clear everything (R12)
      wr_en = 1'b1; wr_idx = '0; wr_exist = ~m_ex[0]; // must be dropped (R2)
      wr_g = 1'b0; wr_asid = '0; wr_vppn = '0; wr_ps = '0;
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      check("R12", int'(busy), 1, "busy during walk");
      while (!done) @(negedge clk);
      @(negedge clk);
      check("R12", int'(busy), 0, "no second walk after refused start");
      check("R12", n, TOT, "scope size");
      verify_all("R12_R2");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule